// File: doc/BRIEF.md
# Daisy-Chain Device Index Enumerator

This block gives a memory device its position on a shared serial side-band bus without any address strap pins. Every device on the bus sees the same reset line and serial clock. Each device's serial output feeds the serial input of the next device, and the first device has its input tied low. While reset is held, every device drives its chain output high, so the whole chain fills with ones. Once reset is released, a single zero starts at the head of the chain and moves one device further per serial clock cycle.

Each device counts sampling edges from the edge on which it first sees reset released to the edge on which its chain input first reads zero. That count is its index on the bus. On the edge where it sees the zero, it latches the count, raises a done flag and pulls its own chain output low. The next device therefore sees the zero exactly one cycle later. All inputs are taken on the falling edge of the serial clock. The command input plays no part in this sequence.

Top module: `chain_index_enum`

## Requirements
- R1: On every falling edge where reset is sampled high, the state clears: after that edge the chain output is 1, the done flag is 0 and the index is 0, whatever the chain input carries.
- R2: The index captured is the number of falling edges from the first edge with reset sampled low (counted as edge 0) to the first later edge with the chain input sampled 0, as an unsigned binary value on the 6-bit index port.
- R3: On the edge that samples the zero, the chain output goes to 0 and the done flag goes to 1, both visible straight after that edge.
- R4: A device whose chain input is 0 on the release edge captures index 0 and drives its chain output low after that same edge.
- R5: The edge counter saturates at MAX_DEVICES-1 (63 by default), so a zero arriving on edge 63 or later captures 63.
- R6: Once done is set, further changes on the chain input leave the index, the done flag and the chain output unchanged until the next reset.
- R7: The command input has no effect on the index, the done flag or the chain output.
- R8: Sampling reset high at any point, in mid-count or after done, clears the state per R1, and a new count starts from the next release.
- R9: In a chain where the head input is tied to 0, the device at position k captures index k and its chain output first reads 0 at the sampling edge k+1 edges after the release edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all inputs sampled on its falling edge |
| rst_smp | input | 1 | Broadcast reset, active high |
| cmd_smp | input | 1 | Command line, unused during enumeration |
| chain_in | input | 1 | Serial input from the upstream device |
| chain_out | output | 1 | Serial output to the downstream device |
| dev_index | output | 6 | Captured position on the chain |
| enum_done | output | 1 | High once the index has been captured |

## Verification
Every result in this block is registered on the falling edge that samples its cause: the cleared state after a reset edge, and the index, done flag and low chain output after the edge that sees the zero. None of them needs a further cycle. The bench changes inputs just after a rising edge and reads outputs at the next rising edge, which falls half a period after the edge under test. Along the chain, the zero from device k reaches device k+1 one edge later, so device k is checked as done from step k onward and as still high before that step.

// File: rtl/chain_enum_pkg.sv
package chain_enum_pkg;

    // Phase of the enumeration sequence
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // no reset seen since power-up
        PH_COUNT = 2'd1,   // reset released, waiting for the zero
        PH_DONE  = 2'd2    // index captured
    } phase_e;

endpackage

// File: rtl/chain_idx_counter.sv
// Saturating edge counter for the enumeration window.
module chain_idx_counter #(
    parameter int CNT_W   = 6,
    parameter int CNT_MAX = 63
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (inc && (st_q.cnt != LIMIT)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(negedge clk) begin
        st_q <= st_d;
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/chain_idx_capture.sv
// Holds the captured index, the done flag and the chain output.
module chain_idx_capture #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             cap,
    input  logic [IDX_W-1:0] cnt_val,
    output logic [IDX_W-1:0] idx,
    output logic             done,
    output logic             out
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             done;
        logic             out;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.idx  = '0;
            st_d.done = 1'b0;
            st_d.out  = 1'b1;
        end else if (cap) begin
            st_d.idx  = cnt_val;
            st_d.done = 1'b1;
            st_d.out  = 1'b0;
        end
    end

    always_ff @(negedge clk) begin
        st_q <= st_d;
    end

    assign idx  = st_q.idx;
    assign done = st_q.done;
    assign out  = st_q.out;

endmodule

// File: rtl/chain_index_enum.sv
// Reset-time self-addressing for one device on a daisy-chained serial bus.
module chain_index_enum
    import chain_enum_pkg::*;
#(
    parameter int MAX_DEVICES = 64
) (
    input  logic                           sclk,
    input  logic                           rst_smp,
    input  logic                           cmd_smp,
    input  logic                           chain_in,
    output logic                           chain_out,
    output logic [$clog2(MAX_DEVICES)-1:0] dev_index,
    output logic                           enum_done
);

    localparam int IDX_W = $clog2(MAX_DEVICES);

    typedef struct packed {
        phase_e phase;
    } top_state_t;

    top_state_t        st_d, st_q;
    logic              clr_w, cap_w, inc_w;
    logic [IDX_W-1:0]  cnt_w;
    logic              unused_cmd;

    // the command line takes no part in enumeration
    assign unused_cmd = cmd_smp;

    always_comb begin
        st_d  = st_q;
        clr_w = rst_smp;
        cap_w = 1'b0;
        inc_w = 1'b0;
        if (rst_smp) begin
            st_d.phase = PH_COUNT;
        end else if (st_q.phase == PH_COUNT) begin
            if (!chain_in) begin
                cap_w      = 1'b1;
                st_d.phase = PH_DONE;
            end else begin
                inc_w = 1'b1;
            end
        end
    end

    always_ff @(negedge sclk) begin
        st_q <= st_d;
    end

    chain_idx_counter #(
        .CNT_W   (IDX_W),
        .CNT_MAX (MAX_DEVICES - 1)
    ) u_counter (
        .clk   (sclk),
        .clr   (clr_w),
        .inc   (inc_w),
        .count (cnt_w)
    );

    chain_idx_capture #(
        .IDX_W (IDX_W)
    ) u_capture (
        .clk     (sclk),
        .clr     (clr_w),
        .cap     (cap_w),
        .cnt_val (cnt_w),
        .idx     (dev_index),
        .done    (enum_done),
        .out     (chain_out)
    );

endmodule

// File: rtl/chain_index_enum_chk.sv
module chain_index_enum_chk #(
    parameter int MAX_DEVICES = 64
) (
    input logic                           sclk,
    input logic                           rst_smp,
    input logic                           chain_in,
    input logic                           chain_out,
    input logic [$clog2(MAX_DEVICES)-1:0] dev_index,
    input logic                           enum_done
);

    // R1 / R8: the edge after a reset edge shows the cleared state
    assert_reset_clears_R1: assert property (@(negedge sclk) disable iff (rst_smp)
        $past(rst_smp) |-> (chain_out && !enum_done && dev_index == '0));

    // R2: done only rises after a zero was sampled on the chain input
    assert_capture_on_zero_R2: assert property (@(negedge sclk) disable iff (rst_smp)
        $rose(enum_done) |-> $past(!chain_in));

    // R3: the chain output is low as soon as done is raised
    assert_forward_zero_R3: assert property (@(negedge sclk) disable iff (rst_smp)
        $rose(enum_done) |-> !chain_out);

    // R6: once done, everything holds until reset
    assert_done_holds_R6: assert property (@(negedge sclk) disable iff (rst_smp)
        enum_done |=> (enum_done && !chain_out && $stable(dev_index)));

endmodule

bind chain_index_enum chain_index_enum_chk #(
    .MAX_DEVICES (MAX_DEVICES)
) u_chk (
    .sclk      (sclk),
    .rst_smp   (rst_smp),
    .chain_in  (chain_in),
    .chain_out (chain_out),
    .dev_index (dev_index),
    .enum_done (enum_done)
);

// File: tb/test_chain_index_enum.sv
module test_chain_index_enum;

    localparam int CLK_PERIOD = 10;
    localparam int N_CHAIN    = 6;
    localparam int NV         = 9;
    localparam int DELAYS   [NV] = '{0, 1, 2, 5, 31, 62, 63, 64, 70};
    localparam bit CMD_TOG  [NV] = '{0, 0, 1, 0, 1, 0, 0, 1, 0};

    logic       sclk = 1'b1;
    logic       rst  = 1'b0;
    logic       cmd  = 1'b0;
    logic       s_in = 1'b1;
    logic       s_out, s_done;
    logic [5:0] s_idx;

    logic       c_link [N_CHAIN+1];
    logic       c_done [N_CHAIN];
    logic [5:0] c_idx  [N_CHAIN];

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) sclk = ~sclk;

    chain_index_enum i_chain_index_enum (
        .sclk      (sclk),
        .rst_smp   (rst),
        .cmd_smp   (cmd),
        .chain_in  (s_in),
        .chain_out (s_out),
        .dev_index (s_idx),
        .enum_done (s_done)
    );

    assign c_link[0] = 1'b0;

    for (genvar k = 0; k < N_CHAIN; k++) begin : g_chain
        chain_index_enum i_chain_index_enum (
            .sclk      (sclk),
            .rst_smp   (rst),
            .cmd_smp   (cmd),
            .chain_in  (c_link[k]),
            .chain_out (c_link[k+1]),
            .dev_index (c_idx[k]),
            .enum_done (c_done[k])
        );
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // inputs change right after a rising edge; the falling edge in between
    // samples them, and results are read at the next rising edge
    task automatic step();
        @(posedge sclk);
    endtask

    task automatic check_cleared(input string req);
        check(s_out == 1'b1, {req, " chain_out"}, int'(s_out), 1);
        check(s_done == 1'b0, {req, " done"}, int'(s_done), 0);
        check(s_idx == 6'd0, {req, " index"}, int'(s_idx), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: a single reset edge clears, even with the chain input low
        rst = 1'b1; s_in = 1'b0;
        step();
        check_cleared("R1");
        step();
        check(s_out == 1'b1, "R1 chain_out held while reset", int'(s_out), 1);

        // table walk: zero arrives on edge d after release
        for (int v = 0; v < NV; v++) begin
            int d;
            int exp;
            string tag;
            d   = DELAYS[v];
            exp = (d > 63) ? 63 : d;
            if (CMD_TOG[v])  tag = "R7";
            else if (d >= 63) tag = "R5";
            else if (d == 0)  tag = "R4";
            else              tag = "R2";
            rst = 1'b1; cmd = 1'b0; s_in = 1'b1;
            repeat (5) step();
            check_cleared("R8");
            rst = 1'b0;
            for (int n = 0; n <= d; n++) begin
                s_in = (n >= d) ? 1'b0 : 1'b1;
                if (CMD_TOG[v]) cmd = ~cmd;
                step();
                if (n < d) begin
                    if (s_done !== 1'b0 || s_out !== 1'b1) begin
                        check(1'b0, {tag, " early done"}, int'(s_done), 0);
                    end
                end
            end
            check(s_done == 1'b1, {tag, " done"}, int'(s_done), 1);
            check(s_idx == 6'(exp), {tag, " index"}, int'(s_idx), exp);
            check(s_out == 1'b0, "R3 chain_out low after capture", int'(s_out), 0);
        end
        cmd = 1'b0;

        // R6: chain input changes after done are ignored
        rst = 1'b1; s_in = 1'b1;
        repeat (5) step();
        rst = 1'b0;
        for (int n = 0; n <= 3; n++) begin
            s_in = (n == 3) ? 1'b0 : 1'b1;
            step();
        end
        for (int n = 0; n < 4; n++) begin
            s_in = (n == 1) ? 1'b0 : 1'b1;
            cmd  = n[0];
            step();
            check(s_idx == 6'd3, "R6 index held", int'(s_idx), 3);
            check(s_done == 1'b1 && s_out == 1'b0, "R6 done and output held",
                  int'({s_done, s_out}), 2);
        end
        cmd = 1'b0;

        // R8: reset reasserted mid-count, then a fresh count
        rst = 1'b1;
        repeat (5) step();
        rst = 1'b0; s_in = 1'b1;
        repeat (10) step();
        rst = 1'b1;
        step();
        check_cleared("R8 mid-count");
        rst = 1'b0;
        for (int n = 0; n <= 4; n++) begin
            s_in = (n == 4) ? 1'b0 : 1'b1;
            step();
        end
        check(s_done == 1'b1, "R8 done after restart", int'(s_done), 1);
        check(s_idx == 6'd4, "R8 index after restart", int'(s_idx), 4);

        // R9: chained devices
        rst = 1'b1;
        repeat (5) step();
        for (int k = 0; k < N_CHAIN; k++) begin
            check(c_link[k+1] == 1'b1, "R9 chain high in reset", int'(c_link[k+1]), 1);
        end
        rst = 1'b0;
        for (int n = 0; n <= N_CHAIN + 1; n++) begin
            step();
            for (int k = 0; k < N_CHAIN; k++) begin
                bit want;
                want = (n >= k);
                check(c_link[k+1] == ~want, "R9 chain_out timing", int'(c_link[k+1]), int'(~want));
                check(c_done[k] == want, "R9 done timing", int'(c_done[k]), int'(want));
                if (want) begin
                    check(c_idx[k] == 6'(k), "R9 index", int'(c_idx[k]), k);
                end
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule